// File: doc/BRIEF.md
# Half-Duplex Serial Transmitter with Bus Direction Control

This block sends bytes as asynchronous serial frames with no parity: one low start bit, eight data bits with the least significant bit first, and one high stop bit. It is meant to sit in front of a half-duplex differential line transceiver. Bytes arrive on a valid/ready input. A bit-period divider is derived from the clock frequency and the baud rate, which defaults to 115200.

When a byte is accepted while the block is idle, the driver enable goes high at once. The line is then held high for a configurable number of lead-in bit times before the first start bit. Further bytes offered during the burst are queued in a one-byte holding register and sent back to back. The driver stays on for the whole burst. After the last stop bit has been fully sent, a trailing guard of configurable bit times follows, and only then does the driver enable drop. The receive enable is the complement of the driver enable, so the node never drives and listens at the same time.

The controlling state machine has six states:

- IDLE: waiting for a byte.
- LEAD: lead-in guard.
- START: start bit.
- DATA: data bits.
- STOP: stop bit.
- TAIL: trailing guard.

Its transitions are:

- IDLE→LEAD on an accepted byte, or IDLE→START when the lead-in guard is zero.
- LEAD→START after the lead-in guard.
- START→DATA after one bit time.
- DATA→STOP after eight bits.
- STOP→START when another byte is available.
- STOP→TAIL when no byte is available, or STOP→IDLE when the trailing guard is zero.
- TAIL→IDLE after the trailing guard.

Top module: `half_duplex_uart_tx`

## Requirements
- R1: Out of reset and whenever the block is idle, the outputs are as follows: tx_line is 1, drv_en is 0, rx_en is 1, busy is 0 and in_ready is 1.
- R2: Each frame is sent as follows:
  - one bit time low (start);
  - eight data bits, least significant bit first;
  - one bit time high (stop).

  One bit time is CLK_FREQ_HZ/BAUD_RATE clock cycles.
- R3: drv_en goes high in the cycle after the clock edge that accepts a byte in idle. tx_line then stays high for GUARD_LEAD bit times before the start bit.
- R4: drv_en stays high through the final stop bit and then for GUARD_TAIL more bit times. For a burst of N bytes it is high for exactly (GUARD_LEAD + 10·N + GUARD_TAIL) bit times, and then it returns low.
- R5: A byte accepted before the current stop bit ends has its start bit sent directly after that stop bit. drv_en does not drop between the two frames.
- R6: During a burst, in_ready is low while the holding register is full and throughout the trailing guard.
- R7: rx_en is always the complement of drv_en, and busy always equals drv_en.
- R8: tx_line is never low while drv_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | in_data is offered |
| in_ready | output | 1 | Byte is taken on a clock edge where in_valid and in_ready are both high |
| tx_line | output | 1 | Serial output, idles high |
| drv_en | output | 1 | Line driver enable |
| rx_en | output | 1 | Line receiver enable |
| busy | output | 1 | Burst in progress |

## Verification
The assertions check several rules on every cycle: the idle output levels, the complementary direction enables, the rule that the line is never low without the driver, a high line on the cycle the driver turns on, and a high line with in_ready low just before the driver turns off. Exact bit order, bit timing, lead-in and tail lengths, and back-to-back framing can only be shown by the bench's bursts. It compares every cycle of each burst against a waveform computed from the bytes it offered. The scenarios include directed all-zero, all-one and alternating bytes, gap-free bursts that fill the holding register, and random bursts with random gaps.

// File: rtl/hdtx_pkg.sv
package hdtx_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_TAIL
    } hdtx_state_e;
endpackage

// File: rtl/hdtx_baud_gen.sv
module hdtx_baud_gen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_zero,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n || hold_zero) begin
            count <= '0;
        end else if (count == LAST) begin
            count <= '0;
        end else begin
            count <= count + CW'(1);
        end
    end

    assign tick = !hold_zero && (count == LAST);
endmodule

// File: rtl/hdtx_shifter.sv
module hdtx_shifter
    import hdtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    output logic              lsb
);
    logic [DATA_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '1;
        end else if (load) begin
            sh <= load_data;
        end else if (shift) begin
            sh <= {1'b1, sh[DATA_W-1:1]};
        end
    end

    assign lsb = sh[0];
endmodule

// File: rtl/hdtx_hold.sv
module hdtx_hold
    import hdtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (rd) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/half_duplex_uart_tx.sv
module half_duplex_uart_tx
    import hdtx_pkg::*;
#(
    parameter int CLK_FREQ_HZ = 250_000_000,
    parameter int BAUD_RATE   = 115_200,
    parameter int GUARD_LEAD  = 1,
    parameter int GUARD_TAIL  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              tx_line,
    output logic              drv_en,
    output logic              rx_en,
    output logic              busy
);
    localparam int DIV     = CLK_FREQ_HZ / BAUD_RATE;
    localparam int MAXC_A  = (GUARD_LEAD > DATA_W) ? GUARD_LEAD : DATA_W;
    localparam int MAXC    = (GUARD_TAIL > MAXC_A) ? GUARD_TAIL : MAXC_A;
    localparam int CNT_W   = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] LEAD_LAST = (GUARD_LEAD > 0) ? CNT_W'(GUARD_LEAD - 1) : '0;
    localparam logic [CNT_W-1:0] TAIL_LAST = (GUARD_TAIL > 0) ? CNT_W'(GUARD_TAIL - 1) : '0;
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    hdtx_state_e       state, next_state;
    logic [CNT_W-1:0]  bit_idx, next_idx;
    logic              tick;
    logic              accept;
    logic              stop_end;
    logic              more;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              sh_load;
    logic [DATA_W-1:0] sh_data;
    logic              sh_shift;
    logic              sh_lsb;

    hdtx_baud_gen #(.DIV(DIV)) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_zero (state == ST_IDLE),
        .tick      (tick)
    );

    assign accept   = in_valid && in_ready;
    assign stop_end = (state == ST_STOP) && tick;
    assign more     = hold_full || accept;

    hdtx_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (accept && (state != ST_IDLE) && !stop_end),
        .wr_data (in_data),
        .rd      (stop_end && hold_full),
        .full    (hold_full),
        .data    (hold_data)
    );

    assign sh_load  = ((state == ST_IDLE) && accept) || (stop_end && more);
    assign sh_data  = ((state == ST_STOP) && hold_full) ? hold_data : in_data;
    assign sh_shift = (state == ST_DATA) && tick;

    hdtx_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_data (sh_data),
        .shift     (sh_shift),
        .lsb       (sh_lsb)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
        end else begin
            state   <= next_state;
            bit_idx <= next_idx;
        end
    end

    // Next-state logic
    always_comb begin
        next_state = state;
        next_idx   = bit_idx;
        unique case (state)
            ST_IDLE: begin
                next_idx = '0;
                if (accept) begin
                    next_state = (GUARD_LEAD > 0) ? ST_LEAD : ST_START;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    if (bit_idx == LEAD_LAST) begin
                        next_state = ST_START;
                        next_idx   = '0;
                    end else begin
                        next_idx = bit_idx + CNT_W'(1);
                    end
                end
            end
            ST_START: begin
                if (tick) begin
                    next_state = ST_DATA;
                    next_idx   = '0;
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (bit_idx == DATA_LAST) begin
                        next_state = ST_STOP;
                        next_idx   = '0;
                    end else begin
                        next_idx = bit_idx + CNT_W'(1);
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    next_idx = '0;
                    if (more) begin
                        next_state = ST_START;
                    end else if (GUARD_TAIL > 0) begin
                        next_state = ST_TAIL;
                    end else begin
                        next_state = ST_IDLE;
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    if (bit_idx == TAIL_LAST) begin
                        next_state = ST_IDLE;
                        next_idx   = '0;
                    end else begin
                        next_idx = bit_idx + CNT_W'(1);
                    end
                end
            end
            default: begin
                next_state = ST_IDLE;
                next_idx   = '0;
            end
        endcase
    end

    // Output decode
    always_comb begin
        tx_line  = 1'b1;
        drv_en   = 1'b1;
        in_ready = !hold_full;
        unique case (state)
            ST_IDLE: begin
                drv_en   = 1'b0;
                in_ready = 1'b1;
            end
            ST_LEAD:  tx_line = 1'b1;
            ST_START: tx_line = 1'b0;
            ST_DATA:  tx_line = sh_lsb;
            ST_STOP:  tx_line = 1'b1;
            ST_TAIL:  in_ready = 1'b0;
            default: begin
                drv_en   = 1'b0;
                in_ready = 1'b0;
            end
        endcase
        rx_en = !drv_en;
        busy  = drv_en;
    end
endmodule

// File: rtl/hdtx_checker.sv
module hdtx_checker #(
    parameter int GUARD_LEAD = 1,
    parameter int GUARD_TAIL = 1
) (
    input logic clk,
    input logic rst_n,
    input logic tx_line,
    input logic drv_en,
    input logic rx_en,
    input logic busy,
    input logic in_ready
);
    // R8
    line_low_needs_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_line |-> drv_en);

    // R1
    idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |-> (tx_line && rx_en && !busy && in_ready));

    // R7
    direction_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en != drv_en) && (busy == drv_en));

    // R4
    release_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en) |-> $past(tx_line));

    generate
        if (GUARD_LEAD > 0) begin : g_lead
            // R3
            lead_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(drv_en) |-> tx_line);
        end
        if (GUARD_TAIL > 0) begin : g_tail
            // R6
            tail_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(drv_en) |-> !$past(in_ready));
        end
    endgenerate
endmodule

bind half_duplex_uart_tx hdtx_checker #(
    .GUARD_LEAD(GUARD_LEAD),
    .GUARD_TAIL(GUARD_TAIL)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_line  (tx_line),
    .drv_en   (drv_en),
    .rx_en    (rx_en),
    .busy     (busy),
    .in_ready (in_ready)
);

// File: tb/half_duplex_uart_tx_tb.sv
module half_duplex_uart_tx_tb;
    localparam int CLK_HZ = 921_600;
    localparam int BAUD   = 115_200;
    localparam int DIV    = CLK_HZ / BAUD;
    localparam int LEAD   = 2;
    localparam int TAIL   = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready, tx_line, drv_en, rx_en, busy;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit stall_seen;
    logic [7:0] q [8];

    always #2 clk = ~clk;

    half_duplex_uart_tx #(
        .CLK_FREQ_HZ(CLK_HZ),
        .BAUD_RATE  (BAUD),
        .GUARD_LEAD (LEAD),
        .GUARD_TAIL (TAIL)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .tx_line  (tx_line),
        .drv_en   (drv_en),
        .rx_en    (rx_en),
        .busy     (busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_tx(input int k, input int n);
        int slot = k / DIV;
        int s;
        if (slot < LEAD) return 1'b1;
        s = slot - LEAD;
        if (s >= 10 * n) return 1'b1;
        if (s % 10 == 0) return 1'b0;
        if (s % 10 == 9) return 1'b1;
        return q[s / 10][(s % 10) - 1];
    endfunction

    task automatic drive_burst(input int n, input int max_gap);
        for (int i = 0; i < n; i++) begin
            bit acc;
            in_data  = q[i];
            in_valid = 1'b1;
            do begin
                acc = in_ready;
                if (!acc) stall_seen = 1'b1;
                @(negedge clk);
            end while (!acc);
            in_valid = 1'b0;
            if (max_gap > 0) begin
                repeat ($urandom_range(max_gap)) @(negedge clk);
            end
        end
    endtask

    task automatic watch_burst(input int n);
        int total = (LEAD + 10 * n + TAIL) * DIV;
        int wave_err = 0, lead_err = 0, en_err = 0, pair_err = 0, tail_err = 0, idle_err = 0;
        int first_act = 0, first_exp = 0, first_k = -1;
        while (!drv_en) begin
            if (!tx_line) idle_err++;
            @(negedge clk);
        end
        for (int k = 0; k < total; k++) begin
            bit e = exp_tx(k, n);
            if (tx_line !== e) begin
                if (k < LEAD * DIV) lead_err++;
                else wave_err++;
                if (first_k < 0) begin
                    first_k = k; first_act = tx_line; first_exp = e;
                end
            end
            if (drv_en !== 1'b1) en_err++;
            if (rx_en !== 1'b0 || busy !== 1'b1) pair_err++;
            if (k >= (LEAD + 10 * n) * DIV && in_ready !== 1'b0) tail_err++;
            @(negedge clk);
        end
        chk(lead_err == 0, "R3 lead-in line high", lead_err, 0);
        chk(wave_err == 0, (n > 1) ? "R2/R5 frame waveform" : "R2 frame waveform", first_act, first_exp);
        chk(en_err == 0, "R4/R5 driver held over burst", en_err, 0);
        chk(drv_en === 1'b0 && rx_en === 1'b1, "R4 driver released after tail", drv_en, 0);
        chk(pair_err == 0, "R7 enable complement", pair_err, 0);
        chk(tail_err == 0, "R6 not ready in tail", tail_err, 0);
        chk(idle_err == 0, "R8 line high without driver", idle_err, 0);
    endtask

    task automatic burst(input int n, input int max_gap);
        fork
            drive_burst(n, max_gap);
            watch_burst(n);
        join
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1c0ffee));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tx_line === 1'b1 && drv_en === 1'b0 && rx_en === 1'b1 && busy === 1'b0 && in_ready === 1'b1,
            "R1 idle outputs", {tx_line, drv_en, rx_en, busy, in_ready}, 5'b10101);

        q[0] = 8'h00; burst(1, 0);
        q[0] = 8'hFF; burst(1, 0);
        q[0] = 8'hA5; burst(1, 0);

        // R6: gap-free burst fills the holding register
        stall_seen = 1'b0;
        q[0] = 8'h01; q[1] = 8'h80; q[2] = 8'h5A; q[3] = 8'hC3;
        burst(4, 0);
        chk(stall_seen, "R6 in_ready low with hold full", stall_seen, 1);

        // R1 after a burst
        chk(tx_line === 1'b1 && drv_en === 1'b0 && in_ready === 1'b1,
            "R1 idle after burst", {tx_line, drv_en, in_ready}, 3'b101);

        for (int b = 0; b < 30; b++) begin
            int n = $urandom_range(6, 1);
            for (int i = 0; i < n; i++) q[i] = 8'($urandom);
            burst(n, (b % 2 == 0) ? 0 : 3 * DIV);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule